// File: doc/BRIEF.md
# Asynchronous Serial Frame Receiver

This block watches one asynchronous serial line and turns each incoming character frame back into a data word. A 16-bit divisor, supplied as a low byte and a high byte, sets the rate of a sampling tick. That tick runs at sixteen times the bit rate. The word length, parity use, parity sense and a forced-parity mode are plain static inputs. The surrounding logic changes them only while the line is idle.

Each finished frame produces one word. The word carries four flags: parity error, framing error, break and overrun. The word and its flags go into a one-entry holding stage that presents them on a valid/ready output. Back-pressure follows these rules:
- Once `out_valid` is high, it stays high, and the data and flags stay unchanged, until a cycle in which `out_ready` is high.
- A new word may enter the holding stage in the same cycle that the old one is taken.
- If a frame completes while the stage is full and is not being emptied, the new word is dropped. The loss is reported on the next word that is accepted.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `out_valid` is 0 and stays 0 while the line rests at mark (1).
- R2: A frame is one start bit of 0, then the data bits with the least significant bit first, then an optional parity bit, then a stop bit of 1. The data bits appear on `out_data` with the first received bit in bit 0.
- R3: `word_len` selects the data width: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. The unused upper bits of `out_data` read 0.
- R4: With `par_en`=1 and `par_stick`=0, a parity bit follows the data. With `par_even`=1, the data bits and the parity bit together must hold an even number of ones. With `par_even`=0, they must hold an odd number. A mismatch sets `out_perr`.
- R5: With `par_en`=1 and `par_stick`=1, the parity bit must equal the inverse of `par_even`: 0 when `par_even`=1 and 1 when `par_even`=0. Any other value sets `out_perr`.
- R6: If the first stop bit samples as 0 and the frame is not a break, the word is still delivered, with `out_ferr`=1. The receiver then waits for the line to return to 1 before it looks for a new start bit. Only the first stop bit is checked, so any number of stop bits is accepted.
- R7: If every sampling point of a frame reads 0 (start, data, parity when enabled, and stop), the block delivers one word with data 0, `out_brk`=1, `out_ferr`=0 and `out_perr`=0. The next frame is not recognised until the line has gone back to 1.
- R8: A low pulse shorter than half a bit period is treated as a false start. It produces no word.
- R9: If a frame completes while the holding stage is full and `out_ready` is 0, that word is discarded. The next word that is accepted carries `out_ovr`=1, and later words carry `out_ovr`=0 again.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and all four flags hold their values. A cycle with `out_valid`=1 and `out_ready`=1 removes the word.
- R11: The divisor is {`div_hi`,`div_lo`}. A value N gives a bit period of 16·N clock cycles. A value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, asynchronous to clk, idle at 1 |
| div_lo | input | 8 | Low byte of the rate divisor |
| div_hi | input | 8 | High byte of the rate divisor |
| word_len | input | 2 | Data width code (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity when 1, odd when 0; also sets the forced value |
| par_stick | input | 1 | Forced-parity mode |
| out_valid | output | 1 | Holding stage contains a word |
| out_ready | input | 1 | Consumer takes the word this cycle |
| out_data | output | 8 | Received data, right-aligned |
| out_perr | output | 1 | Parity error for this word |
| out_ferr | output | 1 | Framing error for this word |
| out_brk | output | 1 | Break for this word |
| out_ovr | output | 1 | At least one word was dropped just before this one |

## Verification
The hardest case to reach is an overrun. It only occurs when a whole second frame finishes while the first word is still held. The stimulus therefore keeps `out_ready` low across two complete frames. It then confirms that the held word has not changed, takes it, and sends a third frame to see the loss reported. Break and false start are just as timing-bound. The bench holds the line at space for twelve bit times to produce a break. It drives a low pulse of only four sampling ticks, with the divisor known, to produce a false start. A normal frame follows each of these to show that the receiver recovered.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int OSR    = 16;
  localparam int WORD_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_MARK
  } rx_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] data;
    logic              perr;
    logic              ferr;
    logic              brk;
  } rx_word_t;
endpackage

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rxf_baud.sv
module rxf_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;

  // a zero divisor runs like a divisor of one
  assign limit = (divisor == '0) ? '0 : divisor - 1'b1;
  assign tick  = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rxf_deframer.sv
module rxf_deframer
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       done,
  output rx_word_t   word
);
  localparam int SUB_W = $clog2(OSR);
  localparam logic [SUB_W-1:0] MID_START = SUB_W'(OSR/2 - 1);
  localparam logic [SUB_W-1:0] MID_BIT   = SUB_W'(OSR - 1);

  rx_state_e         st;
  logic [SUB_W-1:0]  sub;
  logic [2:0]        bitn;
  logic [WORD_W-1:0] sr;
  logic              pbit;
  logic              all_space;

  logic [2:0]        last_idx;
  logic [2:0]        align_sh;
  logic [WORD_W-1:0] aligned;
  logic              exp_par;
  logic              is_brk;

  assign last_idx = {1'b0, word_len} + 3'd4;
  assign align_sh = 3'd3 - {1'b0, word_len};
  assign aligned  = sr >> align_sh;
  assign exp_par  = par_stick ? ~par_even : (par_even ? ^aligned : ~^aligned);
  assign is_brk   = all_space && !rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sub       <= '0;
      bitn      <= '0;
      sr        <= '0;
      pbit      <= 1'b0;
      all_space <= 1'b0;
      done      <= 1'b0;
      word      <= '0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        unique case (st)
          S_IDLE: begin
            if (!rxd) begin
              st  <= S_START;
              sub <= '0;
            end
          end
          S_START: begin
            if (sub == MID_START) begin
              if (!rxd) begin
                st        <= S_DATA;
                sub       <= '0;
                bitn      <= '0;
                sr        <= '0;
                all_space <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end else begin
              sub <= sub + 1'b1;
            end
          end
          S_DATA: begin
            sub <= sub + 1'b1;
            if (sub == MID_BIT) begin
              sr        <= {rxd, sr[WORD_W-1:1]};
              all_space <= all_space & ~rxd;
              if (bitn == last_idx) st <= par_en ? S_PAR : S_STOP;
              else                  bitn <= bitn + 1'b1;
            end
          end
          S_PAR: begin
            sub <= sub + 1'b1;
            if (sub == MID_BIT) begin
              pbit      <= rxd;
              all_space <= all_space & ~rxd;
              st        <= S_STOP;
            end
          end
          S_STOP: begin
            sub <= sub + 1'b1;
            if (sub == MID_BIT) begin
              done      <= 1'b1;
              word.data <= aligned;
              word.brk  <= is_brk;
              word.ferr <= !rxd && !is_brk;
              word.perr <= par_en && (pbit != exp_par) && !is_brk;
              st        <= rxd ? S_IDLE : S_MARK;
            end
          end
          S_MARK: begin
            if (rxd) st <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import rxf_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_line,
  input  logic [DIV_W/2-1:0] div_lo,
  input  logic [DIV_W/2-1:0] div_hi,
  input  logic [1:0]         word_len,
  input  logic               par_en,
  input  logic               par_even,
  input  logic               par_stick,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [WORD_W-1:0]  out_data,
  output logic               out_perr,
  output logic               out_ferr,
  output logic               out_brk,
  output logic               out_ovr
);
  logic     rxd_s;
  logic     tick;
  logic     fr_done;
  rx_word_t fr_word;

  rx_word_t hold_word;
  logic     hold_ovr;
  logic     ovr_pend;
  logic     accept;

  rxf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rx_line), .q(rxd_s)
  );

  rxf_baud #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .divisor({div_hi, div_lo}), .tick(tick)
  );

  rxf_deframer u_deframe (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd_s),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .done(fr_done), .word(fr_word)
  );

  assign accept = fr_done && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      hold_word <= '0;
      hold_ovr  <= 1'b0;
      ovr_pend  <= 1'b0;
    end else if (fr_done) begin
      if (accept) begin
        out_valid <= 1'b1;
        hold_word <= fr_word;
        hold_ovr  <= ovr_pend;
        ovr_pend  <= 1'b0;
      end else begin
        ovr_pend  <= 1'b1;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_data = hold_word.data;
  assign out_perr = hold_word.perr;
  assign out_ferr = hold_word.ferr;
  assign out_brk  = hold_word.brk;
  assign out_ovr  = hold_ovr;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_perr,
  input logic       out_ferr,
  input logic       out_brk,
  input logic       out_ovr,
  input logic [1:0] word_len,
  input logic       fr_done,
  input logic       ovr_pend
);
  p_hold_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) &&
      $stable({out_perr, out_ferr, out_brk, out_ovr}));

  p_brk_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_brk |-> !out_ferr && !out_perr && out_data == 8'h00);

  p_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && word_len == 2'd0 |-> out_data[7:5] == 3'b000);

  p_drop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done && out_valid && !out_ready |=> ovr_pend);

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_done |=> !fr_done);
endmodule

bind serial_frame_rx rxf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_perr(out_perr), .out_ferr(out_ferr),
  .out_brk(out_brk), .out_ovr(out_ovr), .word_len(word_len),
  .fr_done(fr_done), .ovr_pend(ovr_pend)
);

// File: tb/sim_serial_frame_rx.sv
module sim_serial_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [7:0] div_lo = 8'd2;
  logic [7:0] div_hi = 8'd0;
  logic [1:0] word_len = 2'd3;
  logic       par_en = 1'b0;
  logic       par_even = 1'b0;
  logic       par_stick = 1'b0;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_perr, out_ferr, out_brk, out_ovr;

  int n_cmp = 0;
  int n_bad = 0;
  int bit_clks = 32;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  serial_frame_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .div_lo(div_lo),
    .div_hi(div_hi), .word_len(word_len), .par_en(par_en),
    .par_even(par_even), .par_stick(par_stick), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_perr(out_perr),
    .out_ferr(out_ferr), .out_brk(out_brk), .out_ovr(out_ovr)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic hold_bits(input int n);
    repeat (n * bit_clks) @(negedge clk);
  endtask

  task automatic set_div(input int d);
    div_lo = d[7:0];
    div_hi = d[15:8];
    bit_clks = 16 * ((d == 0) ? 1 : d);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb,
                            input bit use_par, input logic pbit, input logic stopb);
    rx_line = 1'b0;
    hold_bits(1);
    for (int i = 0; i < nb; i++) begin
      rx_line = d[i];
      hold_bits(1);
    end
    if (use_par) begin
      rx_line = pbit;
      hold_bits(1);
    end
    rx_line = stopb;
    hold_bits(1);
    rx_line = 1'b1;
    hold_bits(2);
  endtask

  task automatic expect_word(input string tag, input logic [7:0] d, input logic pe,
                             input logic fe, input logic bk, input logic ov);
    int t = 0;
    while (!out_valid && t < 40 * bit_clks) begin
      @(negedge clk);
      t++;
    end
    chk(out_valid == 1'b1, {tag, " valid"}, out_valid, 1);
    chk(out_data == d, {tag, " data"}, out_data, d);
    chk({out_perr, out_ferr, out_brk, out_ovr} == {pe, fe, bk, ov},
        {tag, " flags pe/fe/bk/ov"}, {out_perr, out_ferr, out_brk, out_ovr},
        {pe, fe, bk, ov});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, {tag, " pop clears valid (R10)"}, out_valid, 0);
  endtask

  task automatic expect_none(input string tag, input int cycles);
    bit seen = 1'b0;
    repeat (cycles) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    chk(!seen, {tag, " no word"}, seen, 0);
  endtask

  task automatic t_reset;
    expect_none("R1 idle after reset", 4 * bit_clks);
  endtask

  task automatic t_basic;
    send_frame(8'hA5, 8, 0, 0, 1);
    expect_word("R2 8-bit A5", 8'hA5, 0, 0, 0, 0);
    send_frame(8'h3C, 8, 0, 0, 1);
    expect_word("R2 8-bit 3C", 8'h3C, 0, 0, 0, 0);
  endtask

  task automatic t_wlen;
    word_len = 2'd0;
    send_frame(8'hF5, 5, 0, 0, 1);
    expect_word("R3 5-bit", 8'h15, 0, 0, 0, 0);
    word_len = 2'd2;
    send_frame(8'hDA, 7, 0, 0, 1);
    expect_word("R3 7-bit", 8'h5A, 0, 0, 0, 0);
    word_len = 2'd3;
  endtask

  task automatic t_parity;
    par_en = 1'b1;
    par_even = 1'b1;
    send_frame(8'h07, 8, 1, ^8'h07, 1);
    expect_word("R4 even good", 8'h07, 0, 0, 0, 0);
    send_frame(8'h07, 8, 1, ~^8'h07, 1);
    expect_word("R4 even bad", 8'h07, 1, 0, 0, 0);
    par_even = 1'b0;
    send_frame(8'h96, 8, 1, ~^8'h96, 1);
    expect_word("R4 odd good", 8'h96, 0, 0, 0, 0);
    send_frame(8'h96, 8, 1, ^8'h96, 1);
    expect_word("R4 odd bad", 8'h96, 1, 0, 0, 0);
  endtask

  task automatic t_stick;
    par_en = 1'b1;
    par_stick = 1'b1;
    par_even = 1'b1;
    send_frame(8'h01, 8, 1, 1'b0, 1);
    expect_word("R5 stick even=1 bit0", 8'h01, 0, 0, 0, 0);
    send_frame(8'h01, 8, 1, 1'b1, 1);
    expect_word("R5 stick even=1 bit1", 8'h01, 1, 0, 0, 0);
    par_even = 1'b0;
    send_frame(8'h03, 8, 1, 1'b1, 1);
    expect_word("R5 stick even=0 bit1", 8'h03, 0, 0, 0, 0);
    par_stick = 1'b0;
    par_en = 1'b0;
  endtask

  task automatic t_frame;
    send_frame(8'h5E, 8, 0, 0, 0);
    expect_word("R6 framing", 8'h5E, 0, 1, 0, 0);
    send_frame(8'h42, 8, 0, 0, 1);
    expect_word("R6 recovers", 8'h42, 0, 0, 0, 0);
  endtask

  task automatic t_break;
    rx_line = 1'b0;
    hold_bits(12);
    rx_line = 1'b1;
    hold_bits(2);
    expect_word("R7 break", 8'h00, 0, 0, 1, 0);
    send_frame(8'h81, 8, 0, 0, 1);
    expect_word("R7 after break", 8'h81, 0, 0, 0, 0);
  endtask

  task automatic t_false_start;
    rx_line = 1'b0;
    repeat (4 * (bit_clks / 16)) @(negedge clk);
    rx_line = 1'b1;
    expect_none("R8 false start", 3 * bit_clks);
    send_frame(8'hC3, 8, 0, 0, 1);
    expect_word("R8 frame after glitch", 8'hC3, 0, 0, 0, 0);
  endtask

  task automatic t_overrun;
    send_frame(8'h11, 8, 0, 0, 1);
    send_frame(8'h22, 8, 0, 0, 1);
    chk(out_valid && out_data == 8'h11, "R10 held word kept under back-pressure",
        out_data, 8'h11);
    chk(out_ovr == 1'b0, "R9 held word has no overrun flag", out_ovr, 0);
    expect_word("R9 first word", 8'h11, 0, 0, 0, 0);
    send_frame(8'h33, 8, 0, 0, 1);
    expect_word("R9 word after loss", 8'h33, 0, 0, 0, 1);
    send_frame(8'h44, 8, 0, 0, 1);
    expect_word("R9 flag cleared", 8'h44, 0, 0, 0, 0);
  endtask

  task automatic t_divisor;
    set_div(5);
    hold_bits(2);
    send_frame(8'h6E, 8, 0, 0, 1);
    expect_word("R11 divisor 5", 8'h6E, 0, 0, 0, 0);
    set_div(0);
    hold_bits(2);
    send_frame(8'h91, 8, 0, 0, 1);
    expect_word("R11 divisor 0 as 1", 8'h91, 0, 0, 0, 0);
    set_div(2);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 reset state", out_valid, 0);
    t_reset();
    t_basic();
    t_wlen();
    t_parity();
    t_stick();
    t_frame();
    t_break();
    t_false_start();
    t_overrun();
    t_divisor();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule